// File: doc/BRIEF.md
# Page-Buffered Flash and EEPROM Write Controller

This block lets a command front end store data into a small simulated non-volatile memory. Flash data is written a page at a time. The front end first fills a page buffer one byte at a time. The word offset comes from the low address bits, and each word takes its low byte before its high byte. One commit request then copies the whole buffer into the flash page named by the upper address bits. EEPROM data is written one byte at a time, and each byte write erases and rewrites its location in a single step.

A single countdown models the programming time. The `busy` output stays high for a fixed, parameterised number of cycles after each accepted flash commit or EEPROM write. While it is high, any read of the flash page or EEPROM byte being programmed returns 0xFF. Software can therefore detect completion by polling until the value it wrote reads back. This fails when the written value is itself 0xFF; in that case the caller has to wait out the full write time.

Write and load requests that arrive during programming are dropped and set a sticky error flag. A high-byte load into a buffer word that has not yet taken its low byte sets a separate sticky ordering flag.

Top module: `flash_page_writer`

## Requirements
- R1: After reset, `busy`, `busyErr` and `orderErr` are low, and every flash byte and every EEPROM byte reads 0xFF.
- R2: A low-byte load writes `wrData` into bits 7:0 of the buffer word selected by the low OFF_BITS bits of `addr`. A high-byte load writes `wrData` into bits 15:8 of that word.
- R3: A page commit copies every buffer word, all in the same clock edge, into the flash page selected by the upper PAGE_BITS bits of `addr`. Buffer word i goes to flash word address {page, i}. Other pages are left unchanged.
- R4: After an accepted page commit, `busy` is high for exactly FLASH_CYC cycles. After an accepted EEPROM write, it is high for exactly EE_CYC cycles.
- R5: While a page commit is in progress, a flash read of any offset in the page being programmed returns 0xFF. Flash reads of other pages return their stored bytes.
- R6: Once `busy` has fallen, reads of a programmed location return the newly written data.
- R7: An EEPROM write replaces the byte at the low EE_BITS bits of `addr`. During the write, reads of that byte return 0xFF, and reads of other EEPROM bytes return their stored value.
- R8: Load, commit and EEPROM write requests made while `busy` is high change no stored data. Each such request sets `busyErr`, which stays high until reset.
- R9: A high-byte load into a word whose low byte has not been loaded since the last commit (or since reset) sets `orderErr`, which stays high until reset. Loads in the correct order leave it low.
- R10: Every page commit returns the whole page buffer to 0xFFFF. A later commit with no loads in between writes 0xFFFF to every word of its page.
- R11: A read request is answered one cycle later. `rdValid` is high and `rdData` holds the selected byte: EEPROM when `rdEe` is 1; otherwise flash, with the high byte when `rdHi` is 1 and the low byte when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadLoReq | input | 1 | Load `wrData` into the low byte of a buffer word |
| loadHiReq | input | 1 | Load `wrData` into the high byte of a buffer word |
| pageWrReq | input | 1 | Commit the page buffer to the flash page at `addr` |
| eeWrReq | input | 1 | Write `wrData` to the EEPROM byte at `addr` |
| rdReq | input | 1 | Read request |
| rdEe | input | 1 | Read selects EEPROM (1) or flash (0) |
| rdHi | input | 1 | Flash read returns the high byte (1) or low byte (0) |
| addr | input | OFF_BITS+PAGE_BITS | Word address (page in upper bits, offset in lower bits) or EEPROM byte address |
| wrData | input | 8 | Byte to load or write |
| rdData | output | 8 | Read result |
| rdValid | output | 1 | `rdData` holds the answer to the previous cycle's read |
| busy | output | 1 | Programming in progress |
| busyErr | output | 1 | Sticky: a request arrived while busy |
| orderErr | output | 1 | Sticky: high byte loaded before low byte |

## Verification
The bench builds the block with four words per page, four pages, four EEPROM bytes, FLASH_CYC of 6 and EE_CYC of 4. With these values every flash word, both of its bytes and every EEPROM byte can be written and read back in a full sweep. Each busy window is also short enough to poll on every one of its cycles. The bench alternates polls of the page being programmed with reads of a neighbouring page, and counts the window length cycle by cycle. It also issues requests inside a window to confirm they are ignored.

// File: rtl/flash_page_writer_pkg.sv
package flash_page_writer_pkg;

  // Per-cycle strobes from the control to the datapath
  typedef struct packed {
    logic loadLo;      // accepted low-byte load
    logic loadHi;      // accepted high-byte load
    logic commitPage;  // accepted page commit
    logic writeEe;     // accepted EEPROM byte write
    logic pollFlash;   // a flash page is being programmed
    logic pollEe;      // an EEPROM byte is being programmed
  } fwStrobe_t;

endpackage

// File: rtl/fwc_ctrl.sv
module fwc_ctrl
  import flash_page_writer_pkg::*;
#(
  parameter int FLASH_CYC = 2000,
  parameter int EE_CYC    = 1000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      loadLoReq,
  input  logic      loadHiReq,
  input  logic      pageWrReq,
  input  logic      eeWrReq,
  input  logic      hiUnpaired,
  output fwStrobe_t st,
  output logic      busy,
  output logic      busyErr,
  output logic      orderErr
);

  localparam int MAX_CYC = (FLASH_CYC > EE_CYC) ? FLASH_CYC : EE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] FLASH_LOAD = CNT_W'(FLASH_CYC);
  localparam logic [CNT_W-1:0] EE_LOAD    = CNT_W'(EE_CYC);

  logic [CNT_W-1:0] remain;
  logic             progFlash;
  logic             anyReq;

  assign busy   = (remain != '0);
  assign anyReq = loadLoReq | loadHiReq | pageWrReq | eeWrReq;

  // Fixed priority: commit, EEPROM write, low load, high load
  always_comb begin
    st            = '0;
    st.commitPage = !busy && pageWrReq;
    st.writeEe    = !busy && !pageWrReq && eeWrReq;
    st.loadLo     = !busy && !pageWrReq && !eeWrReq && loadLoReq;
    st.loadHi     = !busy && !pageWrReq && !eeWrReq && !loadLoReq && loadHiReq;
    st.pollFlash  = busy && progFlash;
    st.pollEe     = busy && !progFlash;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain    <= '0;
      progFlash <= 1'b0;
      busyErr   <= 1'b0;
      orderErr  <= 1'b0;
    end else begin
      if (st.commitPage) begin
        remain    <= FLASH_LOAD;
        progFlash <= 1'b1;
      end else if (st.writeEe) begin
        remain    <= EE_LOAD;
        progFlash <= 1'b0;
      end else if (busy) begin
        remain <= remain - 1'b1;
      end
      if (busy && anyReq)              busyErr  <= 1'b1;
      if (st.loadHi && hiUnpaired)     orderErr <= 1'b1;
    end
  end

  // Length of the current busy window, counted independently of remain
  int runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            runLen <= 0;
    else if (st.commitPage || st.writeEe) runLen <= 0;
    else if (busy)                        runLen <= runLen + 1;
  end

  assert_busy_starts_R4: assert property (@(posedge clk) disable iff (!rstN)
    (st.commitPage || st.writeEe) |=> busy);

  assert_busy_length_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == (progFlash ? FLASH_CYC : EE_CYC)));

  assert_busy_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    busyErr |=> busyErr);

  assert_busy_req_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && anyReq) |=> busyErr);

  assert_order_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    orderErr |=> orderErr);

endmodule

// File: rtl/fwc_datapath.sv
module fwc_datapath
  import flash_page_writer_pkg::*;
#(
  parameter int OFF_BITS  = 6,
  parameter int PAGE_BITS = 3,
  parameter int EE_BITS   = 5,
  localparam int ADDR_W   = OFF_BITS + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  fwStrobe_t         st,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              rdReq,
  input  logic              rdEe,
  input  logic              rdHi,
  output logic              hiUnpaired,
  output logic [7:0]        rdData,
  output logic              rdValid
);

  localparam int WORDS    = 1 << OFF_BITS;
  localparam int PAGES    = 1 << PAGE_BITS;
  localparam int EE_BYTES = 1 << EE_BITS;

  logic [OFF_BITS-1:0]  offs;
  logic [PAGE_BITS-1:0] page;
  logic [EE_BITS-1:0]   eeIdx;
  assign offs  = addr[OFF_BITS-1:0];
  assign page  = addr[ADDR_W-1:OFF_BITS];
  assign eeIdx = addr[EE_BITS-1:0];

  logic [15:0]          pageBuf [WORDS];
  logic [WORDS-1:0]     loSeen;
  logic [7:0]           eeMem [EE_BYTES];
  logic [PAGE_BITS-1:0] progPage;
  logic [EE_BITS-1:0]   progEe;
  logic [PAGES-1:0][15:0] pageRd;

  assign hiUnpaired = !loSeen[offs];

  // Page buffer with low-byte tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < WORDS; w++) pageBuf[w] <= 16'hFFFF;
      loSeen <= '0;
    end else if (st.commitPage) begin
      for (int w = 0; w < WORDS; w++) pageBuf[w] <= 16'hFFFF;
      loSeen <= '0;
    end else if (st.loadLo) begin
      pageBuf[offs][7:0] <= wrData;
      loSeen[offs]       <= 1'b1;
    end else if (st.loadHi) begin
      pageBuf[offs][15:8] <= wrData;
    end
  end

  // One storage bank per flash page
  for (genvar pg = 0; pg < PAGES; pg++) begin : gPage
    logic [15:0] words [WORDS];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int w = 0; w < WORDS; w++) words[w] <= 16'hFFFF;
      end else if (st.commitPage && page == PAGE_BITS'(pg)) begin
        for (int w = 0; w < WORDS; w++) words[w] <= pageBuf[w];
      end
    end
    assign pageRd[pg] = words[offs];
  end

  // EEPROM array and programming targets
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < EE_BYTES; b++) eeMem[b] <= 8'hFF;
      progPage <= '0;
      progEe   <= '0;
    end else begin
      if (st.writeEe) begin
        eeMem[eeIdx] <= wrData;
        progEe       <= eeIdx;
      end
      if (st.commitPage) progPage <= page;
    end
  end

  // Registered read port with polling mask
  logic [15:0] flashWord;
  assign flashWord = pageRd[page];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= 8'hFF;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdReq;
      if (rdReq) begin
        if (rdEe)
          rdData <= (st.pollEe && eeIdx == progEe) ? 8'hFF : eeMem[eeIdx];
        else if (st.pollFlash && page == progPage)
          rdData <= 8'hFF;
        else
          rdData <= rdHi ? flashWord[15:8] : flashWord[7:0];
      end
    end
  end

  assert_buffer_cleared_R10: assert property (@(posedge clk) disable iff (!rstN)
    st.commitPage |=> (pageBuf[0] == 16'hFFFF && loSeen == '0));

  assert_flash_poll_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdEe && st.pollFlash && page == progPage) |=> rdData == 8'hFF);

  assert_ee_poll_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdEe && st.pollEe && eeIdx == progEe) |=> rdData == 8'hFF);

  assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> rdValid);

endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer
  import flash_page_writer_pkg::*;
#(
  parameter int OFF_BITS  = 6,
  parameter int PAGE_BITS = 3,
  parameter int EE_BITS   = 5,
  parameter int FLASH_CYC = 2000,
  parameter int EE_CYC    = 1000,
  localparam int ADDR_W   = OFF_BITS + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadLoReq,
  input  logic              loadHiReq,
  input  logic              pageWrReq,
  input  logic              eeWrReq,
  input  logic              rdReq,
  input  logic              rdEe,
  input  logic              rdHi,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              busy,
  output logic              busyErr,
  output logic              orderErr
);

  fwStrobe_t st;
  logic      hiUnpaired;

  fwc_ctrl #(
    .FLASH_CYC(FLASH_CYC),
    .EE_CYC   (EE_CYC)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadLoReq (loadLoReq),
    .loadHiReq (loadHiReq),
    .pageWrReq (pageWrReq),
    .eeWrReq   (eeWrReq),
    .hiUnpaired(hiUnpaired),
    .st        (st),
    .busy      (busy),
    .busyErr   (busyErr),
    .orderErr  (orderErr)
  );

  fwc_datapath #(
    .OFF_BITS (OFF_BITS),
    .PAGE_BITS(PAGE_BITS),
    .EE_BITS  (EE_BITS)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .addr      (addr),
    .wrData    (wrData),
    .rdReq     (rdReq),
    .rdEe      (rdEe),
    .rdHi      (rdHi),
    .hiUnpaired(hiUnpaired),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );

endmodule

// File: tb/tb_flash_page_writer.sv
`timescale 1ns/1ps
module tb_flash_page_writer;

  localparam int OFF_BITS  = 2;
  localparam int PAGE_BITS = 2;
  localparam int EE_BITS   = 2;
  localparam int FLASH_CYC = 6;
  localparam int EE_CYC    = 4;
  localparam int ADDR_W    = OFF_BITS + PAGE_BITS;
  localparam int WORDS     = 1 << OFF_BITS;
  localparam int PAGES     = 1 << PAGE_BITS;
  localparam int EE_BYTES  = 1 << EE_BITS;

  logic clk = 1'b0;
  logic rstN;
  logic loadLoReq, loadHiReq, pageWrReq, eeWrReq, rdReq, rdEe, rdHi;
  logic [ADDR_W-1:0] addr;
  logic [7:0] wrData, rdData;
  logic rdValid, busy, busyErr, orderErr;

  always #2.5 clk = ~clk;

  flash_page_writer #(
    .OFF_BITS(OFF_BITS), .PAGE_BITS(PAGE_BITS), .EE_BITS(EE_BITS),
    .FLASH_CYC(FLASH_CYC), .EE_CYC(EE_CYC)
  ) dut (
    .clk(clk), .rstN(rstN), .loadLoReq(loadLoReq), .loadHiReq(loadHiReq),
    .pageWrReq(pageWrReq), .eeWrReq(eeWrReq), .rdReq(rdReq), .rdEe(rdEe),
    .rdHi(rdHi), .addr(addr), .wrData(wrData), .rdData(rdData),
    .rdValid(rdValid), .busy(busy), .busyErr(busyErr), .orderErr(orderErr)
  );

  int nChk = 0;
  int nFail = 0;
  logic [15:0] fm [PAGES*WORDS];
  logic [7:0]  em [EE_BYTES];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearReqs();
    loadLoReq = 0; loadHiReq = 0; pageWrReq = 0; eeWrReq = 0;
    rdReq = 0; rdEe = 0; rdHi = 0;
  endtask

  task automatic pulse(input int kind, input logic [ADDR_W-1:0] a, input logic [7:0] d);
    addr = a; wrData = d;
    case (kind)
      0: loadLoReq = 1;
      1: loadHiReq = 1;
      2: pageWrReq = 1;
      default: eeWrReq = 1;
    endcase
    @(negedge clk);
    clearReqs();
  endtask

  task automatic readByte(input logic ee, input logic hi, input logic [ADDR_W-1:0] a,
                          output logic [7:0] d);
    addr = a; rdEe = ee; rdHi = hi; rdReq = 1;
    @(negedge clk);
    clearReqs();
    if (!rdValid) begin
      nChk++; nFail++;
      $display("FAIL R11 rdValid actual=0 expected=1");
    end
    d = rdData;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic verifyFlash(input string req);
    logic [7:0] d;
    for (int w = 0; w < PAGES*WORDS; w++) begin
      readByte(0, 0, ADDR_W'(w), d); check(req, d, fm[w][7:0]);
      readByte(0, 1, ADDR_W'(w), d); check(req, d, fm[w][15:8]);
    end
  endtask

  task automatic verifyEe(input string req);
    logic [7:0] d;
    for (int b = 0; b < EE_BYTES; b++) begin
      readByte(1, 0, ADDR_W'(b), d); check(req, d, em[b]);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    #(5ns * 150000);
    nChk++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [7:0] d;
    int k;
    clearReqs();
    addr = '0; wrData = '0; rstN = 0;
    for (int w = 0; w < PAGES*WORDS; w++) fm[w] = 16'hFFFF;
    for (int b = 0; b < EE_BYTES; b++) em[b] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 busyErr", busyErr, 0);
    check("R1 orderErr", orderErr, 0);
    verifyFlash("R1 flash erased");
    verifyEe("R1 eeprom erased");

    // R2 R3 R4 R5 R6: fill and commit every page, polling during the window
    for (int p = 0; p < PAGES; p++) begin
      for (int o = 0; o < WORDS; o++) begin
        logic [7:0] lo, hi;
        lo = 8'(p*37 + o*11 + 3);
        hi = 8'(p*13 + o*29 + 64);
        pulse(0, ADDR_W'(o), lo);
        pulse(1, ADDR_W'(o), hi);
      end
      pulse(2, ADDR_W'(p * WORDS), 8'h00);
      k = 0;
      while (busy) begin
        if (k % 2 == 0) begin
          readByte(0, k[2], ADDR_W'(p*WORDS + (k/2) % WORDS), d);
          check("R5 poll own page", d, 8'hFF);
        end else begin
          int q = (p + 1) % PAGES;
          readByte(0, 0, ADDR_W'(q*WORDS + 1), d);
          check("R5 other page readable", d, fm[q*WORDS + 1][7:0]);
        end
        k++;
      end
      check("R4 flash busy length", k, FLASH_CYC);
      for (int o = 0; o < WORDS; o++)
        fm[p*WORDS + o] = {8'(p*13 + o*29 + 64), 8'(p*37 + o*11 + 3)};
      verifyFlash("R3 R6 R2 page committed");
    end
    check("R9 in-order loads leave flag low", orderErr, 0);

    // R10: commit with no loads writes all 0xFFFF
    pulse(2, ADDR_W'(0), 8'h00);
    waitIdle();
    for (int o = 0; o < WORDS; o++) fm[o] = 16'hFFFF;
    verifyFlash("R10 cleared buffer committed");

    // R7 R4: every EEPROM byte
    for (int b = 0; b < EE_BYTES; b++) begin
      pulse(3, ADDR_W'(b), 8'(b*37 + 5));
      k = 0;
      while (busy) begin
        if (k % 2 == 0) begin
          readByte(1, 0, ADDR_W'(b), d);
          check("R7 poll own byte", d, 8'hFF);
        end else begin
          int c = (b + 1) % EE_BYTES;
          readByte(1, 0, ADDR_W'(c), d);
          check("R7 other byte readable", d, em[c]);
        end
        k++;
      end
      if (b == 0) check("R4 eeprom busy length", k, EE_CYC);
      em[b] = 8'(b*37 + 5);
      verifyEe("R7 R6 byte written");
    end
    check("R8 no error before busy requests", busyErr, 0);

    // R8: requests while busy are dropped
    pulse(3, ADDR_W'(1), 8'h3C);
    check("R8 window open", busy, 1);
    pulse(0, ADDR_W'(0), 8'h12);
    pulse(2, ADDR_W'(2 * WORDS), 8'h00);
    pulse(3, ADDR_W'(2), 8'h77);
    check("R8 busyErr set", busyErr, 1);
    waitIdle();
    em[1] = 8'h3C;
    verifyEe("R8 eeprom unaffected");
    verifyFlash("R8 flash unaffected");
    pulse(2, ADDR_W'(3 * WORDS), 8'h00);
    waitIdle();
    for (int o = 0; o < WORDS; o++) fm[3*WORDS + o] = 16'hFFFF;
    verifyFlash("R8 dropped load absent");
    check("R8 busyErr sticky", busyErr, 1);

    // R9: high byte before low byte
    pulse(1, ADDR_W'(2), 8'hA5);
    check("R9 orderErr set", orderErr, 1);
    repeat (3) @(negedge clk);
    check("R9 orderErr sticky", orderErr, 1);

    finishRun();
  end

endmodule